// File: doc/BRIEF.md
# Cumulative Assertion Duration Timer

This block measures how long an active-low alarm input has been held low in total. Each period of assertion adds to an 8-bit timer, and the timer keeps its value between assertions. Time is counted in units. One unit is a fixed number of pulses on a time-base tick input, set by a parameter. The timer stops at full scale. It clears when the host reads it, and the read returns the value held before the clear.

The timer uses a short-range encoding. As soon as the alarm is seen, bit 0 goes high, even before a full unit has passed, and the value stays at 1 until two whole units have built up. From that point the register is a plain binary count of units. A programmable 8-bit limit is compared with the timer. A sticky flag rises when the timer is above the limit, or on any assertion when the limit is zero. The flag has its own clear strobe.

The control is a four-state machine:
- **CLEAR**: nothing has been counted since the last clear.
- **MARK**: the alarm has been seen, but fewer than two units have built up.
- **COUNT**: the value is a binary count.
- **FULL**: the count is saturated.

The transitions are:
- **arm**: CLEAR to MARK, when the synchronized alarm is active.
- **promote**: CLEAR or MARK to COUNT, when the unit count reaches 2.
- **saturate**: COUNT to FULL, when the unit count reaches 255.
- **flush**: any state to CLEAR, when a read happens with the alarm inactive.
- **rearm**: any state to MARK, when a read happens with the alarm active.

Top module: `assert_duration_timer`

## Requirements
- R1: After reset the timer reads 0, the flag is 0 and the limit is 0xFF.
- R2: The timer counts only while the synchronized alarm is low. It adds one unit for every TICKS_PER_UNIT tick pulses seen while the alarm is active. Released time does not count, and the partial units of separate assertions add together.
- R3: The first assertion after a clear makes the timer read 1, even when no whole unit has built up. The alarm passes through a two-flop synchronizer first.
- R4: The timer keeps reading 1 until two units have built up. From then on it reads the number of whole units in binary, with bit 0 as the least significant bit.
- R5: The timer holds at 255 once it reaches full scale.
- R6: A read returns the current value and clears the timer to 0. Any partial unit is discarded.
- R7: A read while the alarm is active clears the count and immediately sets the timer back to 1. Counting then restarts from zero units.
- R8: The flag sets when the timer value is greater than the limit. It stays set until cleared, and a timer read does not clear it.
- R9: With a limit of 0x00, any assertion of the alarm sets the flag.
- R10: The flag clear strobe resets the flag. When a set condition is present in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| unit_tick | input | 1 | Time-base pulse, one clock wide |
| alarm_n | input | 1 | Raw active-low alarm, asynchronous |
| rd_stb | input | 1 | Host read strobe; clears the timer at this edge |
| rd_data | output | 8 | Timer value returned by the read |
| lim_we | input | 1 | Limit register write enable |
| lim_wdata | input | 8 | Limit value to write |
| flag_clr | input | 1 | Clears the sticky flag |
| flag | output | 1 | Sticky limit-exceeded flag |

## Verification
The hardest case to reach is a read that lands in the middle of an assertion. The count must be returned, then the timer must be re-marked on the next edge, while the synchronizer delay shifts every window by two cycles. The bench holds the alarm low for a known number of cycles and issues two reads back to back. The first read must see the full count and the second must see the re-marked value 1. The bench then releases the alarm and checks that the few cycles still in the synchronizer leave a partial unit that reads as 1. The set-wins case is reached by holding the alarm low with a zero limit while the clear strobe pulses.

// File: rtl/atd_pkg.sv
package atd_pkg;
    typedef enum logic [1:0] {
        S_CLEAR = 2'd0,
        S_MARK  = 2'd1,
        S_COUNT = 2'd2,
        S_FULL  = 2'd3
    } atd_state_t;
endpackage

// File: rtl/atd_sync.sv
module atd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/atd_prescale.sv
module atd_prescale #(
    parameter int TICKS_PER_UNIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    input  logic tick,
    input  logic clr,
    output logic unit_pulse
);
    localparam int SW = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
    localparam logic [SW-1:0] LAST = SW'(TICKS_PER_UNIT - 1);

    logic [SW-1:0] sub_q;

    assign unit_pulse = act && tick && (sub_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              sub_q <= '0;
        else if (clr)            sub_q <= '0;
        else if (act && tick) begin
            if (sub_q == LAST)   sub_q <= '0;
            else                 sub_q <= sub_q + 1'b1;
        end
    end
endmodule

// File: rtl/atd_flag.sv
module atd_flag #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lim_we,
    input  logic [W-1:0] lim_wdata,
    input  logic [W-1:0] tval,
    input  logic         act,
    input  logic         flag_clr,
    output logic         flag,
    output logic [W-1:0] lim_q
);
    logic set_cond;

    assign set_cond = (tval > lim_q) || ((lim_q == '0) && act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lim_q <= '1;
        else if (lim_we) lim_q <= lim_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag <= 1'b0;
        else if (set_cond) flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end
endmodule

// File: rtl/assert_duration_timer.sv
module assert_duration_timer #(
    parameter int W              = 8,
    parameter int TICKS_PER_UNIT = 4,
    parameter int SYNC_STAGES    = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         unit_tick,
    input  logic         alarm_n,
    input  logic         rd_stb,
    output logic [W-1:0] rd_data,
    input  logic         lim_we,
    input  logic [W-1:0] lim_wdata,
    input  logic         flag_clr,
    output logic         flag
);
    import atd_pkg::*;

    localparam logic [W-1:0] MAXV  = '1;
    localparam logic [W-1:0] TWO_U = W'(2);

    logic         alarm_s;
    logic         act;
    logic         unit_pulse;
    logic [W-1:0] units_q, units_nxt;
    logic [W-1:0] tval;
    logic [W-1:0] lim_q;
    atd_state_t   state_q, state_nxt;

    atd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n(rst_n),
        .din (alarm_n),
        .dout(alarm_s)
    );

    assign act = ~alarm_s;

    atd_prescale #(.TICKS_PER_UNIT(TICKS_PER_UNIT)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .tick      (unit_tick),
        .clr       (rd_stb),
        .unit_pulse(unit_pulse)
    );

    always_comb begin
        if (rd_stb)                           units_nxt = '0;
        else if (unit_pulse && units_q != MAXV) units_nxt = units_q + 1'b1;
        else                                  units_nxt = units_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) units_q <= '0;
        else        units_q <= units_nxt;
    end

    always_comb begin
        state_nxt = state_q;
        if (rd_stb) begin
            state_nxt = act ? S_MARK : S_CLEAR;
        end else begin
            unique case (state_q)
                S_CLEAR: begin
                    if (units_nxt >= TWO_U) state_nxt = S_COUNT;
                    else if (act)           state_nxt = S_MARK;
                end
                S_MARK: begin
                    if (units_nxt >= TWO_U) state_nxt = S_COUNT;
                end
                S_COUNT: begin
                    if (units_nxt == MAXV)  state_nxt = S_FULL;
                end
                S_FULL: state_nxt = S_FULL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_CLEAR;
        else        state_q <= state_nxt;
    end

    always_comb begin
        unique case (state_q)
            S_CLEAR: tval = '0;
            S_MARK:  tval = W'(1);
            S_COUNT: tval = units_q;
            S_FULL:  tval = MAXV;
        endcase
    end

    assign rd_data = tval;

    atd_flag #(.W(W)) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .lim_we   (lim_we),
        .lim_wdata(lim_wdata),
        .tval     (tval),
        .act      (act),
        .flag_clr (flag_clr),
        .flag     (flag),
        .lim_q    (lim_q)
    );
endmodule

// File: rtl/atd_checker.sv
module atd_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         rd_stb,
    input logic         flag_clr,
    input logic         flag,
    input logic         act,
    input logic [W-1:0] tval,
    input logic [W-1:0] lim_q
);
    a_r5_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
        (tval == '1 && !rd_stb) |=> (tval == '1));

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !act) |=> (tval == '0));

    a_r7_read_remarks: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && act) |=> (tval == W'(1)));

    a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && !rd_stb) |=> $stable(tval));

    a_r4_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> (tval >= $past(tval)));

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((tval > lim_q) && flag_clr) |=> flag);
endmodule

bind assert_duration_timer atd_checker #(.W(W)) u_atd_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stb  (rd_stb),
    .flag_clr(flag_clr),
    .flag    (flag),
    .act     (act),
    .tval    (tval),
    .lim_q   (lim_q)
);

// File: tb/assert_duration_timer_bench.sv
module assert_duration_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       unit_tick = 1'b1;
    logic       alarm_n = 1'b1;
    logic       rd_stb = 1'b0;
    logic       rd_chk = 1'b0;
    logic [7:0] rd_data;
    logic       lim_we = 1'b0;
    logic [7:0] lim_wdata = 8'h00;
    logic       flag_clr = 1'b0;
    logic       flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    assert_duration_timer u_assert_duration_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .unit_tick(unit_tick),
        .alarm_n  (alarm_n),
        .rd_stb   (rd_stb),
        .rd_data  (rd_data),
        .lim_we   (lim_we),
        .lim_wdata(lim_wdata),
        .flag_clr (flag_clr),
        .flag     (flag)
    );

    task automatic check(input string tag, input logic [7:0] act_v, input logic [7:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act_v, exp_v);
        end
    endtask

    // driver: called at a negedge, ends at the next negedge
    task automatic read_exp(input logic [7:0] exp_v, input string tag);
        exp_q.push_back(exp_v);
        tag_q.push_back(tag);
        rd_stb = 1'b1;
        rd_chk = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        rd_chk = 1'b0;
    endtask

    task automatic read_drop();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic hold_low(input int n);
        alarm_n = 1'b0;
        repeat (n) @(negedge clk);
        alarm_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    // monitor: pops the expected value for each checked read
    always @(negedge clk) begin
        #1;
        if (rd_stb && rd_chk) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL scoreboard: read with empty queue, got %0d expected none", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset timer", rd_data, 8'd0);
        check("R1 reset flag", {7'd0, flag}, 8'd0);
        read_exp(8'd0, "R1 idle read");

        // R3: short assertion (3 active cycles, no whole unit) reads 1
        hold_low(3);
        read_exp(8'd1, "R3 first assertion marks");
        read_exp(8'd0, "R6 read cleared timer");

        // R4/R2: 6 active cycles = 1 unit, still 1; add 2 -> 8 ticks = 2 units
        hold_low(6);
        read_exp(8'd1, "R4 one unit still marked");
        // R6: previous read dropped the partial unit; 6 + 2 only if kept
        hold_low(6);
        hold_low(2);
        read_exp(8'd2, "R2 accumulate across assertions");

        // R2: no tick, no counting
        unit_tick = 1'b0;
        hold_low(20);
        unit_tick = 1'b1;
        read_exp(8'd1, "R2 no count without tick");

        // R4: 20 active cycles = 5 units
        hold_low(20);
        read_exp(8'd5, "R4 binary count");

        // R7: read during assertion
        alarm_n = 1'b0;
        repeat (22) @(negedge clk);
        read_exp(8'd5, "R7 read during assertion returns count");
        read_exp(8'd1, "R7 rearmed immediately");
        alarm_n = 1'b1;
        repeat (5) @(negedge clk);
        read_exp(8'd1, "R7 restart from zero units");

        // R5: saturation, limit 0xFF never exceeded (R1)
        hold_low(1100);
        check("R1 limit 0xFF keeps flag low", {7'd0, flag}, 8'd0);
        read_exp(8'd255, "R5 saturated");

        // R8: limit 3, 5 units exceed it
        lim_we = 1'b1; lim_wdata = 8'd3;
        @(negedge clk);
        lim_we = 1'b0;
        hold_low(12);
        check("R8 three units not above limit", {7'd0, flag}, 8'd0);
        hold_low(8);
        check("R8 flag set above limit", {7'd0, flag}, 8'd1);
        read_exp(8'd5, "R8 timer value");
        @(negedge clk);
        check("R8 read leaves flag set", {7'd0, flag}, 8'd1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        @(negedge clk);
        check("R10 clear resets flag", {7'd0, flag}, 8'd0);

        // R9 / R10: zero limit
        lim_we = 1'b1; lim_wdata = 8'd0;
        @(negedge clk);
        lim_we = 1'b0;
        check("R9 no assertion no flag", {7'd0, flag}, 8'd0);
        alarm_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 zero limit flags on assertion", {7'd0, flag}, 8'd1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        @(negedge clk);
        check("R10 set wins over clear", {7'd0, flag}, 8'd1);
        alarm_n = 1'b1;
        repeat (5) @(negedge clk);
        read_drop();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        @(negedge clk);
        check("R10 clear with no set condition", {7'd0, flag}, 8'd0);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule